// File: doc/BRIEF.md
# Multi-Level Bus Interrupt Arbiter

This block gathers interrupt requests from a row of device slots and offers exactly one of them to the CPU. Each slot has a one-cycle request strobe that carries a two-bit level code and an interrupt vector. The level code selects bus request level 4 through 7. The block keeps one pending entry per slot and masks the entries against the CPU's 3-bit priority. It then picks a winner, highest level first and lowest slot index second, and latches that winner as the candidate shown to the CPU on `irq_pending`.

When the CPU acknowledges, the block returns the candidate's vector and slot for a single cycle and pulses that slot's accepted bit. It then clears the slot's entry and arbitrates again on the next cycle. A slot that strobes again while its entry is still waiting is merged into that entry and is not queued twice. A latched candidate keeps its place against every later arrival. It is released only when the CPU raises its priority far enough to mask it.

Top module: `irq_level_arbiter`

## Requirements
- R1: Each of `NSLOT` slots (default 32) owns one pending entry. A strobe on a slot with no entry stores the level code and the vector given on that cycle. Level code 0, 1, 2, 3 stands for bus level 4, 5, 6, 7. The vector is `VEC_W` bits wide (default 9) and each slot's fields sit at `slot*2` and `slot*VEC_W`.
- R2: An entry of bus level L takes part in arbitration only while L is greater than `cpu_prio`. Priority 7 masks all levels, priority 6 passes only level 7, and priority 0 passes all four.
- R3: Among the enabled entries the highest level wins. Within one level the lowest slot index wins.
- R4: A strobe on a slot whose entry is still waiting is merged into that entry. The first level and vector are kept, and the slot is granted only once.
- R5: When no candidate is held and an enabled entry exists at a clock edge, that winner becomes the candidate at that edge. `irq_pending` is high for as long as a candidate is held.
- R6: A held candidate that is still enabled and not acknowledged stays the candidate, whatever arrives later at any level.
- R7: If `cpu_prio` rises so that it masks the held candidate, the candidate is released at the next edge and `irq_pending` falls. The slot's entry stays pending.
- R8: `grant_ack` sampled high while a candidate is held produces the following for exactly the next cycle: `grant_valid` high, the candidate's vector on `grant_vector`, its index on `grant_slot`, and only its bit set in `accepted`. The entry is cleared and `irq_pending` is low in that cycle.
- R9: `grant_ack` sampled while no candidate is held has no effect.
- R10: Reset (`rst_n` low at a clock edge) clears every entry and the candidate. `irq_pending`, `grant_valid` and `accepted` are then low.
- R11: Entries that arrive while masked stay pending. They are granted in level order as the priority is lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_strobe | input | NSLOT | One-cycle request pulse per slot |
| req_level | input | 2*NSLOT | Level code per slot (0..3 = bus level 4..7) |
| req_vector | input | VEC_W*NSLOT | Interrupt vector per slot |
| cpu_prio | input | 3 | Current CPU priority |
| grant_ack | input | 1 | CPU acknowledge of the presented request |
| irq_pending | output | 1 | A candidate is presented to the CPU |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_vector | output | VEC_W | Vector of the granted request |
| grant_slot | output | $clog2(NSLOT) | Index of the granted slot |
| accepted | output | NSLOT | One-hot per-slot accepted strobe |

## Verification
The hardest case to reach is a held candidate that loses arbitration to nothing. The candidate must stay the same while a lower-index slot at the same level, and then an entry at another level, arrive after it was latched. Otherwise a design that simply re-arbitrates every cycle looks correct. The stimulus loads one level-7 slot alone, lets it latch, and then strobes lower-index level-7 and level-6 slots before acknowledging. It then checks the vector order of the grants. Release on masking is reached by raising the priority between latch and acknowledge. An acknowledge sent while nothing is held follows, and it must produce no grant.

// File: rtl/irq_arb_pkg.sv
// Package irq_arb_pkg
// Shared constants and the level-enable rule used by the interrupt arbiter.
// Assumes levels are coded 0..3 for bus levels 4..7.
package irq_arb_pkg;
    localparam int LVL_W  = 2;
    localparam int NLVL   = 4;
    localparam int PRIO_W = 3;

    // True when a request of the given level code passes the CPU priority.
    function automatic logic lvl_enabled(input logic [LVL_W-1:0] code,
                                         input logic [PRIO_W-1:0] prio);
        return (PRIO_W'(code) + PRIO_W'(4)) > prio;
    endfunction
endpackage

// File: rtl/irq_slot_bank.sv
// Module irq_slot_bank
// Holds one pending entry (flag, level code, vector) per slot.
// A strobe creates an entry only when none is waiting (merge rule).
// The clear input is one-hot and comes from the grant controller.
// Assumes a strobe and a clear on the same slot in one cycle mean a fresh request.
module irq_slot_bank
    import irq_arb_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int VEC_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       strobe,
    input  logic [NSLOT*LVL_W-1:0] level_in,
    input  logic [NSLOT*VEC_W-1:0] vector_in,
    input  logic [NSLOT-1:0]       clear,
    output logic [NSLOT-1:0]       pend,
    output logic [NSLOT*LVL_W-1:0] level_q,
    output logic [NSLOT*VEC_W-1:0] vector_q
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic take;
        assign take = strobe[s] && (!pend[s] || clear[s]);

        // Per-slot pending flag: set by a new strobe, cleared by its grant.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[s] <= 1'b0;
            else if (take)
                pend[s] <= 1'b1;
            else if (clear[s])
                pend[s] <= 1'b0;
        end

        // Per-slot payload: captured only when a new entry is created.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q[s*LVL_W +: LVL_W]  <= '0;
                vector_q[s*VEC_W +: VEC_W] <= '0;
            end else if (take) begin
                level_q[s*LVL_W +: LVL_W]  <= level_in[s*LVL_W +: LVL_W];
                vector_q[s*VEC_W +: VEC_W] <= vector_in[s*VEC_W +: VEC_W];
            end
        end

        // R4: a waiting entry is neither dropped nor overwritten by a repeat strobe.
        a_r4_merge_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[s] && !clear[s]) |=> (pend[s] && $stable(vector_q[s*VEC_W +: VEC_W])));

        // R8: a cleared entry is gone unless the same slot strobed again.
        a_r8_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
            (clear[s] && !strobe[s]) |=> !pend[s]);
    end
endmodule

// File: rtl/irq_pick.sv
// Module irq_pick
// Combinational arbiter: among pending entries enabled by the CPU priority,
// finds the highest level, then the lowest slot index at that level.
// Assumes level codes are 0..3 with 3 the most urgent.
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int NSLOT  = 32,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0]       pend,
    input  logic [NSLOT*LVL_W-1:0] level_q,
    input  logic [PRIO_W-1:0]      prio,
    output logic                   any,
    output logic [SLOT_W-1:0]      win_slot,
    output logic [LVL_W-1:0]       win_lvl
);
    logic [NSLOT-1:0] lvl_mask [NLVL];

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar s = 0; s < NSLOT; s++) begin : g_bit
            assign lvl_mask[l][s] = pend[s] && (level_q[s*LVL_W +: LVL_W] == LVL_W'(l));
        end
    end

    // Selects the top enabled level, then the lowest set slot inside it.
    always_comb begin
        logic [NSLOT-1:0] row;
        any      = 1'b0;
        win_lvl  = '0;
        win_slot = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (lvl_enabled(LVL_W'(l), prio) && (|lvl_mask[l])) begin
                any     = 1'b1;
                win_lvl = LVL_W'(l);
            end
        end
        row = lvl_mask[win_lvl];
        for (int s = NSLOT-1; s >= 0; s--) begin
            if (row[s])
                win_slot = SLOT_W'(s);
        end
    end
endmodule

// File: rtl/irq_grant_ctl.sv
// Module irq_grant_ctl
// Holds the candidate presented to the CPU and runs the acknowledge handshake.
// A held candidate is kept until acknowledged or masked by a priority raise.
// Assumes the slot bank keeps a waiting entry's vector stable (merge rule).
module irq_grant_ctl
    import irq_arb_pkg::*;
#(
    parameter int NSLOT  = 32,
    parameter int VEC_W  = 9,
    parameter int SLOT_W = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   any,
    input  logic [SLOT_W-1:0]      win_slot,
    input  logic [LVL_W-1:0]       win_lvl,
    input  logic [PRIO_W-1:0]      prio,
    input  logic                   grant_ack,
    input  logic [NSLOT*VEC_W-1:0] vector_q,
    output logic [NSLOT-1:0]       clear,
    output logic                   irq_pending,
    output logic                   grant_valid,
    output logic [VEC_W-1:0]       grant_vector,
    output logic [SLOT_W-1:0]      grant_slot,
    output logic [NSLOT-1:0]       accepted
);
    logic              cand_valid;
    logic [SLOT_W-1:0] cand_slot;
    logic [LVL_W-1:0]  cand_lvl;
    logic              fire;
    logic              keep;

    assign fire        = cand_valid && grant_ack;
    assign keep        = cand_valid && lvl_enabled(cand_lvl, prio);
    assign clear       = fire ? (NSLOT'(1) << cand_slot) : '0;
    assign irq_pending = cand_valid;

    // Candidate register: latch a winner, hold it, drop it on grant or mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_valid <= 1'b0;
            cand_slot  <= '0;
            cand_lvl   <= '0;
        end else if (fire) begin
            cand_valid <= 1'b0;
        end else if (!keep) begin
            cand_valid <= any;
            if (any) begin
                cand_slot <= win_slot;
                cand_lvl  <= win_lvl;
            end
        end
    end

    // Grant outputs: one-cycle vector, slot and accepted strobe on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_vector <= '0;
            grant_slot   <= '0;
            accepted     <= '0;
        end else begin
            grant_valid  <= fire;
            grant_vector <= fire ? vector_q[cand_slot*VEC_W +: VEC_W] : '0;
            grant_slot   <= fire ? cand_slot : '0;
            accepted     <= clear;
        end
    end

    // R6: an enabled, unacknowledged candidate is not displaced.
    a_r6_candidate_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !grant_ack && lvl_enabled(cand_lvl, prio))
            |=> (cand_valid && $stable(cand_slot)));

    // R8: the grant strobe lasts exactly one cycle.
    a_r8_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    // R8: accepted is one-hot during a grant and empty otherwise.
    a_r8_accept_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(accepted) == int'(grant_valid));

    // R9: a grant only follows a presented candidate.
    a_r9_grant_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(irq_pending));

    // R7: a candidate masked by the priority is withdrawn at the next edge.
    a_r7_mask_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !grant_ack && !lvl_enabled(cand_lvl, prio) && !any) |=> !irq_pending);
endmodule

// File: rtl/irq_level_arbiter.sv
// Module irq_level_arbiter
// Top of the multi-level interrupt arbiter: slot bank, combinational picker
// and grant controller. Synchronous active-low reset.
// Assumes request strobes are single-cycle pulses with valid level and vector.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NSLOT  = 32,
    parameter int VEC_W  = 9,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSLOT-1:0]       req_strobe,
    input  logic [NSLOT*2-1:0]     req_level,
    input  logic [NSLOT*VEC_W-1:0] req_vector,
    input  logic [2:0]             cpu_prio,
    input  logic                   grant_ack,
    output logic                   irq_pending,
    output logic                   grant_valid,
    output logic [VEC_W-1:0]       grant_vector,
    output logic [SLOT_W-1:0]      grant_slot,
    output logic [NSLOT-1:0]       accepted
);
    logic [NSLOT-1:0]       pend;
    logic [NSLOT*LVL_W-1:0] level_q;
    logic [NSLOT*VEC_W-1:0] vector_q;
    logic [NSLOT-1:0]       clear;
    logic                   any;
    logic [SLOT_W-1:0]      win_slot;
    logic [LVL_W-1:0]       win_lvl;

    irq_slot_bank #(.NSLOT(NSLOT), .VEC_W(VEC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (req_strobe),
        .level_in  (req_level),
        .vector_in (req_vector),
        .clear     (clear),
        .pend      (pend),
        .level_q   (level_q),
        .vector_q  (vector_q)
    );

    irq_pick #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_pick (
        .pend     (pend),
        .level_q  (level_q),
        .prio     (cpu_prio),
        .any      (any),
        .win_slot (win_slot),
        .win_lvl  (win_lvl)
    );

    irq_grant_ctl #(.NSLOT(NSLOT), .VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .any          (any),
        .win_slot     (win_slot),
        .win_lvl      (win_lvl),
        .prio         (cpu_prio),
        .grant_ack    (grant_ack),
        .vector_q     (vector_q),
        .clear        (clear),
        .irq_pending  (irq_pending),
        .grant_valid  (grant_valid),
        .grant_vector (grant_vector),
        .grant_slot   (grant_slot),
        .accepted     (accepted)
    );

    // R10: after a reset edge nothing is presented and nothing is granted.
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq_pending && !grant_valid && accepted == '0));
endmodule

// File: tb/irq_level_arbiter_test.sv
// Bench for irq_level_arbiter: a table of one-cycle steps, then directed cases.
module irq_level_arbiter_test;
    localparam int NSLOT  = 32;
    localparam int VEC_W  = 9;
    localparam int SLOT_W = $clog2(NSLOT);

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [NSLOT-1:0]       req_strobe;
    logic [NSLOT*2-1:0]     req_level;
    logic [NSLOT*VEC_W-1:0] req_vector;
    logic [2:0]             cpu_prio;
    logic                   grant_ack;
    logic                   irq_pending;
    logic                   grant_valid;
    logic [VEC_W-1:0]       grant_vector;
    logic [SLOT_W-1:0]      grant_slot;
    logic [NSLOT-1:0]       accepted;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_level_arbiter #(.NSLOT(NSLOT), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_strobe(req_strobe), .req_level(req_level),
        .req_vector(req_vector), .cpu_prio(cpu_prio), .grant_ack(grant_ack),
        .irq_pending(irq_pending), .grant_valid(grant_valid),
        .grant_vector(grant_vector), .grant_slot(grant_slot), .accepted(accepted)
    );

    // Row: {req, slot[5], lvl[2], vec[9], prio[3], ack, exp_pend, exp_gv, exp_vec[9]}
    localparam int NROW = 38;
    localparam logic [31:0] TBL [NROW] = '{
        // R11/R2: four levels posted under priority 7, none presented
        {1'b1, 5'd3,  2'd0, 9'o040, 3'd7, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b1, 5'd5,  2'd1, 9'o050, 3'd7, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b1, 5'd6,  2'd2, 9'o060, 3'd7, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b1, 5'd7,  2'd3, 9'o070, 3'd7, 1'b0, 1'b0, 1'b0, 9'o000},
        // priority 6 passes only level 7
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd6, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd6, 1'b1, 1'b0, 1'b1, 9'o070},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd6, 1'b0, 1'b0, 1'b0, 9'o000},
        // priority 0: level 6, 5, 4 in turn
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o060},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o050},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o040},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b0, 1'b0, 9'o000},
        // R6/R3: slot 14 latched alone, later lower slots do not displace it
        {1'b1, 5'd14, 2'd3, 9'o040, 3'd0, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b1, 5'd12, 2'd3, 9'o020, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b1, 5'd11, 2'd3, 9'o010, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b1, 5'd2,  2'd2, 9'o120, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o040},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o010},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o020},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o120},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b0, 1'b0, 9'o000},
        // R4: repeat strobe on slot 9 merges; first vector kept, granted once
        {1'b1, 5'd9,  2'd0, 9'o100, 3'd7, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b1, 5'd9,  2'd3, 9'o077, 3'd7, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o100},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b0, 1'b0, 9'o000},
        // R7/R9: priority raise releases candidate; stray ack ignored
        {1'b1, 5'd4,  2'd1, 9'o044, 3'd0, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd5, 1'b0, 1'b0, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd5, 1'b1, 1'b0, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b1, 1'b0, 9'o000},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b1, 1'b0, 1'b1, 9'o044},
        {1'b0, 5'd0,  2'd0, 9'o000, 3'd0, 1'b0, 1'b0, 1'b0, 9'o000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs(input logic [2:0] prio);
        req_strobe = '0;
        req_level  = '0;
        req_vector = '0;
        cpu_prio   = prio;
        grant_ack  = 1'b0;
    endtask

    task automatic post(input int slot, input logic [1:0] lvl, input logic [VEC_W-1:0] vec);
        req_strobe[slot]               = 1'b1;
        req_level[slot*2 +: 2]         = lvl;
        req_vector[slot*VEC_W +: VEC_W] = vec;
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs(3'd0);
        step; step;
        // R10: reset state
        check("R10 reset irq_pending", 32'(irq_pending), 0);
        check("R10 reset grant_valid", 32'(grant_valid), 0);
        check("R10 reset accepted", accepted, 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk (R1 fields: level at slot*2, vector at slot*VEC_W)
        for (int i = 0; i < NROW; i++) begin
            logic [31:0] r;
            r = TBL[i];
            @(negedge clk);
            idle_inputs(r[14:12]);
            if (r[31]) post(int'(r[30:26]), r[25:24], r[23:15]);
            grant_ack = r[11];
            step;
            check($sformatf("R5 row %0d irq_pending", i), 32'(irq_pending), 32'(r[10]));
            check($sformatf("R8 row %0d grant_valid", i), 32'(grant_valid), 32'(r[9]));
            if (r[9])
                check($sformatf("R3 row %0d grant_vector", i), 32'(grant_vector), 32'(r[8:0]));
        end

        // R3/R8: slots 0 and 31 strobe together at level 7; slot 0 first
        @(negedge clk);
        idle_inputs(3'd0);
        post(31, 2'd3, 9'o777);
        post(0, 2'd3, 9'o001);
        step;
        @(negedge clk); idle_inputs(3'd0); step;
        check("R5 dual latch irq_pending", 32'(irq_pending), 1);
        @(negedge clk); grant_ack = 1'b1; step;
        check("R3 dual first slot", 32'(grant_slot), 0);
        check("R8 dual first accepted", accepted, 32'h0000_0001);
        check("R8 dual first vector", 32'(grant_vector), 32'o001);
        @(negedge clk); grant_ack = 1'b0; step;
        check("R8 one-cycle grant", 32'(grant_valid), 0);
        check("R8 no accepted after grant", accepted, 0);
        @(negedge clk); grant_ack = 1'b1; step;
        check("R3 dual second slot", 32'(grant_slot), 31);
        check("R8 dual second accepted", accepted, 32'h8000_0000);
        check("R1 dual second vector", 32'(grant_vector), 32'o777);
        @(negedge clk); grant_ack = 1'b0; step;

        // R10: mid-run reset clears a masked waiting entry
        @(negedge clk);
        idle_inputs(3'd7);
        post(5, 2'd2, 9'o055);
        step;
        @(negedge clk); idle_inputs(3'd7); rst_n = 1'b0; step;
        @(negedge clk); rst_n = 1'b1; cpu_prio = 3'd0; step;
        step; step;
        check("R10 entry cleared by reset", 32'(irq_pending), 0);
        @(negedge clk); grant_ack = 1'b1; step;
        check("R9 ack after reset ignored", 32'(grant_valid), 0);
        @(negedge clk); grant_ack = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule